// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-processor countdown timer behind a small synchronous register bus. Software sets three things: a divide setting that picks how many bus clocks make one timer tick, a timer entry that holds an interrupt vector together with a mask flag and a reload flag, and an initial count. A write to the initial-count register loads the counter and starts the countdown from the moment of that write. On every tick the counter drops by one. When it reaches zero the block emits a one-cycle interrupt request that carries the programmed vector, unless the mask flag is set.

With the reload flag clear, the timer fires once and then rests at zero. With the flag set, it reloads the initial count each time it expires, so it fires at a fixed period. The mask flag silences the request but does not stop the count, so software can park the timer without losing its vector. The running count can be read back at any time. Arbitration among interrupt sources and delivery to a core are handled by other blocks.

Top module: `loc_irq_timer`

## Requirements
- R1: After reset the timer entry reads 0x00010000 (vector 0, mask set, one-shot). The initial count, current count and divide registers read 0, and irq_valid is low.
- R2: A write to the initial count (offset 0x380) loads the counter at that clock edge. The counter then drops by one every R bus clocks, and a read of the current count (offset 0x390) returns the value it held before the read edge.
- R3: In one-shot mode (timer entry bit 17 = 0), irq_valid is high for exactly one cycle, in the cycle after the edge that takes the count from 1 to 0. irq_vector carries bits 7:0 of the timer entry (offset 0x320). The count then holds at 0 and no further request follows.
- R4: In periodic mode (bit 17 = 1), the counter reloads the initial count when it expires, and a request follows every N*R bus clocks after the load.
- R5: With the mask bit (timer entry bit 16) set, no request is raised, but counting and reloading continue.
- R6: The divide code {bit3,bit1,bit0} of offset 0x3E0 selects R = 2^(code+1) for codes 000 to 110, and R = 1 for code 111.
- R7: The divide register stores only bits 3, 1 and 0. All its other bits read back as 0.
- R8: Writing the initial count while a countdown is running restarts the countdown from the new value, timed from the new write.
- R9: An initial count of 0 stops the timer, and no request is raised.
- R10: The current count is read-only. A write to 0x390 changes nothing.
- R11: The counter accepts 32-bit counts such as 1,000,000,000 and 0x7FFFFF without early wrap. A count of 0xF expires after exactly 15 ticks.
- R12: reg_rdata is valid in the cycle after the read edge. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector of the request |

## Verification
Take a write of count N at edge E0 with ratio R. The count read at edge E returns N minus floor((E-1-E0)/R). The request appears in the cycle after edge E0+N*R, and in periodic mode again after each further N*R edges. Read data is ready one cycle after the read edge. Every bus task returns the index of the edge at which its access took effect. The driver turns each arm into an expected edge index and vector, and puts that pair in a queue. A monitor samples irq_valid on falling edges and matches it against the head of the queue. A request that arrives early, one that arrives late or not at all, and one with nothing queued are each reported as a failure.

// File: rtl/lirqt_pkg.sv
package lirqt_pkg;
  localparam int OFF_ENTRY = 'h320;
  localparam int OFF_INIT  = 'h380;
  localparam int OFF_CUR   = 'h390;
  localparam int OFF_DIV   = 'h3E0;
  localparam int MASK_BIT  = 16;
  localparam int PER_BIT   = 17;
  localparam int DIV_CW    = 3;
  localparam int PS_MAX_SHIFT = 7;
  localparam int PS_W      = PS_MAX_SHIFT;

  // Number of doubling stages for a divide code; code 7 means no division.
  function automatic int div_shift(input logic [DIV_CW-1:0] code);
    if (code == {DIV_CW{1'b1}}) return 0;
    return int'(code) + 1;
  endfunction
endpackage

// File: rtl/lirqt_regs.sv
module lirqt_regs
  import lirqt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur_count,
  output logic [DATA_W-1:0] rdata,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  init_q,
  output logic [VEC_W-1:0]  vector,
  output logic              mask,
  output logic              periodic,
  output logic [DIV_CW-1:0] div_code
);
  logic sel_entry, sel_init, sel_cur, sel_div, hit;
  logic [DATA_W-1:0] rd_mux;
  logic unused_bits;

  assign sel_entry = (addr == ADDR_W'(OFF_ENTRY));
  assign sel_init  = (addr == ADDR_W'(OFF_INIT));
  assign sel_cur   = (addr == ADDR_W'(OFF_CUR));
  assign sel_div   = (addr == ADDR_W'(OFF_DIV));
  assign hit       = sel_entry | sel_init | sel_cur | sel_div;

  assign load        = wr & sel_init;
  assign load_val    = wdata[CNT_W-1:0];
  assign unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q   <= '0;
      vector   <= '0;
      mask     <= 1'b1;
      periodic <= 1'b0;
      div_code <= '0;
    end else if (wr) begin
      if (sel_init) init_q <= wdata[CNT_W-1:0];
      if (sel_entry) begin
        vector   <= wdata[VEC_W-1:0];
        mask     <= wdata[MASK_BIT];
        periodic <= wdata[PER_BIT];
      end
      if (sel_div) div_code <= {wdata[3], wdata[1], wdata[0]};
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_entry) begin
      rd_mux[VEC_W-1:0] = vector;
      rd_mux[MASK_BIT]  = mask;
      rd_mux[PER_BIT]   = periodic;
    end else if (sel_init) begin
      rd_mux[CNT_W-1:0] = init_q;
    end else if (sel_cur) begin
      rd_mux[CNT_W-1:0] = cur_count;
    end else if (sel_div) begin
      rd_mux[3] = div_code[2];
      rd_mux[1] = div_code[1];
      rd_mux[0] = div_code[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  // R12: a read of an unmapped offset returns zero on the next cycle
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && !hit) |=> (rdata == '0));

  // R7: the divide field only moves on a write to its own offset
  a_r7_div_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel_div) |=> $stable(div_code));
endmodule

// File: rtl/lirqt_prescaler.sv
module lirqt_prescaler
  import lirqt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [DIV_CW-1:0] div_code,
  output logic              tick
);
  logic [PS_W-1:0] cnt;
  logic [PS_W-1:0] ratio_m1;

  assign ratio_m1 = PS_W'((1 << div_shift(div_code)) - 1);
  assign tick     = (cnt >= ratio_m1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R6: with any ratio above one, two ticks are never adjacent
  a_r6_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && div_code != {DIV_CW{1'b1}}) |=> (!tick || div_code == {DIV_CW{1'b1}}));
endmodule

// File: rtl/lirqt_counter.sv
module lirqt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_q,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick & ~load & (cur == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (load) begin
      cur <= load_val;
    end else if (tick && cur != '0) begin
      if (cur == ONE) cur <= periodic ? init_q : '0;
      else            cur <= cur - ONE;
    end
  end

  // R9: a stopped counter stays stopped until a new load
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (cur == '0 && !load) |=> (cur == '0));

  // R2: each tick takes exactly one off a count above one
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!load && tick && cur > ONE) |=> (cur == $past(cur) - ONE));

  // R2: without a tick or a load the count is frozen
  a_r2_freeze: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cur));

  // R4: expiry in periodic mode restores the initial count
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (!load && tick && cur == ONE && periodic) |=> (cur == $past(init_q)));
endmodule

// File: rtl/loc_irq_timer.sv
module loc_irq_timer
  import lirqt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic              load, mask, periodic, tick, expire;
  logic [CNT_W-1:0]  load_val, init_q, cur;
  logic [VEC_W-1:0]  vector;
  logic [DIV_CW-1:0] div_code;

  lirqt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .cur_count(cur), .rdata(reg_rdata), .load(load),
    .load_val(load_val), .init_q(init_q), .vector(vector), .mask(mask),
    .periodic(periodic), .div_code(div_code)
  );

  lirqt_prescaler u_presc (
    .clk(clk), .rst(rst), .clr(load), .div_code(div_code), .tick(tick)
  );

  lirqt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .init_q(init_q),
    .tick(tick), .periodic(periodic), .cur(cur), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= expire & ~mask;
      if (expire && !mask) irq_vector <= vector;
    end
  end

  // R5: a request only follows a cycle in which the mask was clear
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(!mask));
endmodule

// File: tb/loc_irq_timer_tb.sv
module loc_irq_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  always #5 clk = ~clk;

  loc_irq_timer u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_cyc[$];
  logic [7:0] exp_vec[$];
  int m_c;
  logic [7:0] m_v;

  // Scoreboard monitor: every request must match the head of the queue.
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_valid) begin
        checks++;
        if (exp_cyc.size() == 0) begin
          errors++;
          $display("FAIL R3 R5 R9 unexpected irq: actual edge %0d vec %h, expected none", cyc, irq_vector);
        end else begin
          m_c = exp_cyc.pop_front();
          m_v = exp_vec.pop_front();
          if (m_c != cyc || m_v != irq_vector) begin
            errors++;
            $display("FAIL R3 R4 R6 R8 R11 irq: actual edge %0d vec %h, expected edge %0d vec %h",
                     cyc, irq_vector, m_c, m_v);
          end
        end
      end else if (exp_cyc.size() > 0 && cyc > exp_cyc[0]) begin
        checks++;
        errors++;
        $display("FAIL R3 R4 R6 R8 R11 missed irq: actual none by edge %0d, expected edge %0d", cyc, exp_cyc[0]);
        m_c = exp_cyc.pop_front();
        m_v = exp_vec.pop_front();
      end
    end
  end

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, output int e);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    e = cyc;
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d, output int e);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    e = cyc;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic logic [31:0] oneshot_val(input longint n, input int r, input int e0, input int e);
    longint k;
    k = (e - 1 - e0) / r;
    if (k >= n) return 32'd0;
    return 32'(n - k);
  endfunction

  function automatic logic [31:0] periodic_val(input int n, input int e0, input int e);
    return 32'(n - ((e - 1 - e0) % n));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e0, e1, e;
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 irq_valid", {31'd0, irq_valid}, 32'd0);
    rd_reg(12'h320, d, e); chk("R1 entry", d, 32'h0001_0000);
    rd_reg(12'h380, d, e); chk("R1 init", d, 32'd0);
    rd_reg(12'h390, d, e); chk("R1 cur", d, 32'd0);
    rd_reg(12'h3E0, d, e); chk("R1 div", d, 32'd0);

    // R7 only divide bits 3,1,0 are kept
    wr_reg(12'h3E0, 32'hFFFF_FFFF, e);
    rd_reg(12'h3E0, d, e); chk("R7 div bits", d, 32'h0000_000B);

    // R3 R6 one-shot at ratio 16 (code 011 -> 0x3)
    wr_reg(12'h3E0, 32'h3, e);
    wr_reg(12'h320, 32'h0000_0041, e);
    wr_reg(12'h380, 32'd5, e0);
    exp_cyc.push_back(e0 + 80); exp_vec.push_back(8'h41);
    rd_reg(12'h390, d, e); chk("R2 cur early", d, oneshot_val(5, 16, e0, e));
    wait_until(e0 + 40);
    rd_reg(12'h390, d, e); chk("R2 cur mid", d, oneshot_val(5, 16, e0, e));
    wait_until(e0 + 120);
    rd_reg(12'h390, d, e); chk("R3 hold zero", d, 32'd0);
    chk("R3 queue drained", 32'(exp_cyc.size()), 32'd0);

    // R4 periodic at ratio 1 (code 111 -> 0xB)
    wr_reg(12'h3E0, 32'hB, e);
    wr_reg(12'h320, 32'h0002_0055, e);
    wr_reg(12'h380, 32'd20, e0);
    for (int i = 1; i <= 3; i++) begin
      exp_cyc.push_back(e0 + 20 * i); exp_vec.push_back(8'h55);
    end
    wait_until(e0 + 65);
    // R5 mask silences but the count keeps reloading
    wr_reg(12'h320, 32'h0003_0055, e);
    rd_reg(12'h390, d, e); chk("R5 masked count", d, periodic_val(20, e0, e));
    wait_until(e0 + 103);
    rd_reg(12'h390, d, e); chk("R5 masked reload", d, periodic_val(20, e0, e));
    wait_until(e0 + 130);
    chk("R4 queue drained", 32'(exp_cyc.size()), 32'd0);

    // R9 zero count stops, even once unmasked
    wr_reg(12'h380, 32'd0, e);
    wr_reg(12'h320, 32'h0002_0055, e);
    wait_until(e + 60);
    rd_reg(12'h390, d, e); chk("R9 stopped", d, 32'd0);

    // R8 re-arm mid-countdown
    wr_reg(12'h320, 32'h0000_0022, e);
    wr_reg(12'h380, 32'd30, e0);
    wait_until(e0 + 10);
    wr_reg(12'h380, 32'd12, e1);
    exp_cyc.push_back(e1 + 12); exp_vec.push_back(8'h22);
    wait_until(e1 + 40);
    chk("R8 queue drained", 32'(exp_cyc.size()), 32'd0);

    // R11 minimum event 0xF at ratio 2 (code 000)
    wr_reg(12'h3E0, 32'h0, e);
    rd_reg(12'h3E0, d, e); chk("R6 div readback", d, 32'd0);
    wr_reg(12'h320, 32'h0000_0033, e);
    wr_reg(12'h380, 32'hF, e0);
    exp_cyc.push_back(e0 + 30); exp_vec.push_back(8'h33);
    rd_reg(12'h390, d, e); chk("R11 min count", d, oneshot_val(15, 2, e0, e));
    wait_until(e0 + 50);

    // R6 ratio 64 (code 101 -> 0x9)
    wr_reg(12'h3E0, 32'h9, e);
    wr_reg(12'h320, 32'h0000_0044, e);
    wr_reg(12'h380, 32'd2, e0);
    exp_cyc.push_back(e0 + 128); exp_vec.push_back(8'h44);
    wait_until(e0 + 160);
    chk("R6 queue drained", 32'(exp_cyc.size()), 32'd0);

    // R10 current count is read-only
    wr_reg(12'h390, 32'h0000_1234, e);
    rd_reg(12'h390, d, e); chk("R10 cur unchanged", d, 32'd0);
    rd_reg(12'h380, d, e); chk("R10 init unchanged", d, 32'd2);

    // R11 wide counts, masked so nothing fires
    wr_reg(12'h3E0, 32'hB, e);
    wr_reg(12'h320, 32'h0001_0000, e);
    wr_reg(12'h380, 32'd1000000000, e0);
    rd_reg(12'h390, d, e); chk("R11 big count", d, oneshot_val(1000000000, 1, e0, e));
    rd_reg(12'h380, d, e); chk("R11 big init", d, 32'd1000000000);
    wait_until(e + 100);
    rd_reg(12'h390, d, e); chk("R11 big count later", d, oneshot_val(1000000000, 1, e0, e));
    wr_reg(12'h380, 32'h007F_FFFF, e0);
    wait_until(e0 + 37);
    rd_reg(12'h390, d, e); chk("R11 max event", d, oneshot_val(32'h7F_FFFF, 1, e0, e));
    wr_reg(12'h380, 32'd0, e);

    // R12 unmapped offsets read zero
    rd_reg(12'h100, d, e); chk("R12 unmapped 0x100", d, 32'd0);
    rd_reg(12'h324, d, e); chk("R12 unmapped 0x324", d, 32'd0);

    repeat (5) @(negedge clk);
    chk("final queue empty", 32'(exp_cyc.size()), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule